// File: doc/BRIEF.md
# Flash Command Interface with Status Register

This block is the command front end of a parallel NOR-style flash device. Each bus write cycle brings a data word whose low byte is a command code, together with an address. The block decodes the codes, including two-step setup/confirm pairs for programming and block erase. It selects what a bus read returns: the array contents, the status register, or the array while an erase is parked. It also launches program and erase jobs on an internal write engine.

The engine talks to the block through a one-cycle start pulse and a done pulse that carries a fail flag. A hold request and a parked acknowledge let an erase be suspended and resumed. An 8-bit status register reports engine readiness, the suspend state, and three sticky error flags. The error flags pile up over several operations until software clears them, so a whole batch of writes can be checked with a single poll. A reset clears the status register and returns reads to the array.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset `rd_mode` is 00 (array), `status` is 80h (bit 7 ready, all others 0), and `eng_start` and `eng_hold` are low.
- R2: A write of 40h followed by a second write produces a one-cycle `eng_start` with `eng_erase`=0, carrying the second write's address and data. `rd_mode` becomes 01 (status) and status bit 7 reads 0 until the job is done.
- R3: A write of 20h followed by a write of D0h produces a one-cycle `eng_start` with `eng_erase`=1 and the confirm write's address. Status bit 7 reads 0 while the erase runs.
- R4: If the write after 20h is not D0h, no job starts. Status bits 5 (erase error) and 4 (program error) are set, and `rd_mode` becomes 01.
- R5: A done pulse sets bit 7 back to 1 and leaves `rd_mode` at 01. If `eng_fail` is high with it, bit 4 is set for a program or bit 5 for an erase.
- R6: If `supply_ok` is low on the second write of a program or erase, no job starts. Status bit 3 is set, along with bit 4 (program) or bit 5 (erase).
- R7: Error bits 5:3 stay set across later successful operations. A write of 50h while the engine is ready clears them.
- R8: While the engine is ready, 70h selects `rd_mode` 01 and FFh selects `rd_mode` 00.
- R9: B0h during an erase raises `eng_hold`. Once `eng_parked` is seen, status bits 7 and 6 both read 1. B0h during a program has no effect.
- R10: B0h while no job is running sets `rd_mode` to 00 and does not touch `eng_hold`.
- R11: While suspended, only FFh (`rd_mode` 10, suspended array), 70h and D0h are acted on. D0h drops `eng_hold`, clears bit 6 and returns bit 7 to 0. Other codes, including 50h, 40h and 20h, change neither the status nor the mode, and start no job.
- R12: An unrecognised code leaves the mode and status unchanged. While a job runs, every code other than 70h and B0h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | ADDR_W | Address of the write cycle |
| bus_data | input | DATA_W | Write data; low byte is the command code |
| supply_ok | input | 1 | Programming supply in range |
| eng_done | input | 1 | Engine finished the current job (pulse) |
| eng_fail | input | 1 | Job failed, valid with eng_done |
| eng_parked | input | 1 | Engine has halted the erase under hold |
| rd_mode | output | 2 | 00 array, 01 status, 10 suspended array |
| status | output | 8 | Status register |
| eng_start | output | 1 | One-cycle job launch |
| eng_erase | output | 1 | Job kind: 1 erase, 0 program |
| eng_addr | output | ADDR_W | Job address |
| eng_data | output | DATA_W | Program data |
| eng_hold | output | 1 | Suspend request to the engine |

## Verification
Programs and erases run both cleanly and with engine failures. This shows that each failure lands in the flag for its own operation, and that a later clean run leaves an older flag in place. An erase setup is followed by a wrong code, and operations are launched with the supply low. These two cases cover the other error sources and show they are distinct. Suspend is tried in three ways: during an erase with clear, setup and read commands issued while parked; during a program; and with no job at all. Together these separate a real suspend, an ignored request and a drop to array read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY      = 2'b00,
      RM_STATUS     = 2'b01,
      RM_SUSP_ARRAY = 2'b10
   } rd_mode_e;

   typedef enum logic [2:0] {
      CK_OTHER,
      CK_ARRAY,
      CK_STATUS,
      CK_CLEAR,
      CK_PGM,
      CK_ERS,
      CK_CONFIRM,
      CK_SUSPEND
   } cmd_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PGM,
      PH_ERS
   } phase_e;

   localparam logic [7:0] OPC_READ_ARRAY = 8'hFF;
   localparam logic [7:0] OPC_READ_STAT  = 8'h70;
   localparam logic [7:0] OPC_CLEAR_STAT = 8'h50;
   localparam logic [7:0] OPC_PGM_SETUP  = 8'h40;
   localparam logic [7:0] OPC_ERS_SETUP  = 8'h20;
   localparam logic [7:0] OPC_CONFIRM    = 8'hD0;
   localparam logic [7:0] OPC_SUSPEND    = 8'hB0;

   localparam int SB_READY = 7;
   localparam int SB_SUSP  = 6;
   localparam int SB_ERS   = 5;
   localparam int SB_PGM   = 4;
   localparam int SB_VPP   = 3;

endpackage

// File: rtl/fci_decode.sv
module fci_decode
   import flash_cmd_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_kind_e  kind
);

   always_comb begin
      unique case (cmd_byte)
         OPC_READ_ARRAY: kind = CK_ARRAY;
         OPC_READ_STAT:  kind = CK_STATUS;
         OPC_CLEAR_STAT: kind = CK_CLEAR;
         OPC_PGM_SETUP:  kind = CK_PGM;
         OPC_ERS_SETUP:  kind = CK_ERS;
         OPC_CONFIRM:    kind = CK_CONFIRM;
         OPC_SUSPEND:    kind = CK_SUSPEND;
         default:        kind = CK_OTHER;
      endcase
   end

endmodule

// File: rtl/fci_seq.sv
module fci_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  cmd_kind_e         kind,
   input  logic              supply_ok,
   input  logic              eng_done,
   input  logic              eng_fail,
   input  logic              eng_parked,
   output rd_mode_e          mode,
   output logic              job_active,
   output logic              suspended,
   output logic              eng_start,
   output logic              eng_erase,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_data,
   output logic              eng_hold,
   output logic              set_pgm_err,
   output logic              set_ers_err,
   output logic              set_vpp_err,
   output logic              clr_err
);

   phase_e phase;
   logic   done_now, pgm_go, ers_wr, ers_go, ers_abort;
   logic   launch, launch_ok, idle_wr, ready_wr, busy_wr, park_wr;

   always_comb begin
      done_now    = job_active && eng_done;
      pgm_go      = bus_we && (phase == PH_PGM);
      ers_wr      = bus_we && (phase == PH_ERS);
      ers_go      = ers_wr && (kind == CK_CONFIRM);
      ers_abort   = ers_wr && (kind != CK_CONFIRM);
      launch      = pgm_go || ers_go;
      launch_ok   = launch && supply_ok;
      idle_wr     = bus_we && (phase == PH_IDLE);
      park_wr     = idle_wr && suspended;
      busy_wr     = idle_wr && !suspended && job_active && !done_now;
      ready_wr    = idle_wr && !suspended && !(job_active && !done_now);
      set_vpp_err = launch && !supply_ok;
      set_pgm_err = (pgm_go && !supply_ok) || ers_abort ||
                    (done_now && eng_fail && !eng_erase);
      set_ers_err = (ers_go && !supply_ok) || ers_abort ||
                    (done_now && eng_fail && eng_erase);
      clr_err     = ready_wr && (kind == CK_CLEAR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         mode       <= RM_ARRAY;
         job_active <= 1'b0;
         suspended  <= 1'b0;
         eng_start  <= 1'b0;
         eng_erase  <= 1'b0;
         eng_addr   <= '0;
         eng_data   <= '0;
         eng_hold   <= 1'b0;
      end else begin
         eng_start <= 1'b0;
         if (done_now) begin
            job_active <= 1'b0;
            eng_hold   <= 1'b0;
            suspended  <= 1'b0;
         end else if (eng_hold && eng_parked && !suspended) begin
            suspended <= 1'b1;
         end
         if (launch) begin
            phase <= PH_IDLE;
            mode  <= RM_STATUS;
            if (launch_ok) begin
               eng_start  <= 1'b1;
               job_active <= 1'b1;
               eng_erase  <= ers_go;
               eng_addr   <= bus_addr;
               eng_data   <= pgm_go ? bus_data : '0;
            end
         end
         if (ers_abort) begin
            phase <= PH_IDLE;
            mode  <= RM_STATUS;
         end
         if (park_wr) begin
            unique case (kind)
               CK_ARRAY:   mode <= RM_SUSP_ARRAY;
               CK_STATUS:  mode <= RM_STATUS;
               CK_CONFIRM: begin
                  mode      <= RM_STATUS;
                  eng_hold  <= 1'b0;
                  suspended <= 1'b0;
               end
               default: ;
            endcase
         end
         if (busy_wr) begin
            if (kind == CK_STATUS) mode <= RM_STATUS;
            if (kind == CK_SUSPEND && eng_erase) eng_hold <= 1'b1;
         end
         if (ready_wr) begin
            unique case (kind)
               CK_ARRAY:   mode  <= RM_ARRAY;
               CK_STATUS:  mode  <= RM_STATUS;
               CK_SUSPEND: mode  <= RM_ARRAY;
               CK_PGM:     phase <= PH_PGM;
               CK_ERS:     phase <= PH_ERS;
               default: ;
            endcase
         end
      end
   end

   // R11: nothing is launched while the erase is parked
   a_r11_no_launch_parked: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> !eng_start);
   // R9: hold is only ever raised against a running erase
   a_r9_hold_on_erase: assert property (@(posedge clk) disable iff (!rst_n)
      eng_hold |-> (job_active && eng_erase));
   // R2: launch is a single-cycle pulse
   a_r2_start_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R5: a done pulse retires the job
   a_r5_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (job_active && eng_done) |=> !job_active);

endmodule

// File: rtl/fci_status.sv
module fci_status
   import flash_cmd_pkg::*;
#(
   parameter bit KEEP_SUPPLY_ERR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       job_active,
   input  logic       suspended,
   input  logic       set_pgm_err,
   input  logic       set_ers_err,
   input  logic       set_vpp_err,
   input  logic       clr_err,
   output logic [7:0] status
);

   logic pgm_q, ers_q, vpp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgm_q <= 1'b0;
         ers_q <= 1'b0;
      end else if (clr_err) begin
         pgm_q <= 1'b0;
         ers_q <= 1'b0;
      end else begin
         pgm_q <= pgm_q | set_pgm_err;
         ers_q <= ers_q | set_ers_err;
      end
   end

   generate
      if (KEEP_SUPPLY_ERR) begin : g_vpp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       vpp_q <= 1'b0;
            else if (clr_err) vpp_q <= 1'b0;
            else              vpp_q <= vpp_q | set_vpp_err;
         end
      end else begin : g_no_vpp
         assign vpp_q = 1'b0;
      end
   endgenerate

   always_comb begin
      status           = '0;
      status[SB_READY] = !job_active || suspended;
      status[SB_SUSP]  = suspended;
      status[SB_ERS]   = ers_q;
      status[SB_PGM]   = pgm_q;
      status[SB_VPP]   = vpp_q;
   end

   // R7: error flags hold until an explicit clear
   a_r7_sticky_pgm: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_q && !clr_err) |=> pgm_q);
   a_r7_sticky_ers: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_q && !clr_err) |=> ers_q);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W          = 20,
   parameter int DATA_W          = 16,
   parameter bit KEEP_SUPPLY_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              supply_ok,
   input  logic              eng_done,
   input  logic              eng_fail,
   input  logic              eng_parked,
   output logic [1:0]        rd_mode,
   output logic [7:0]        status,
   output logic              eng_start,
   output logic              eng_erase,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_data,
   output logic              eng_hold
);

   localparam int CMD_W = 8;

   if (DATA_W < CMD_W) begin : g_bad_data_w
      $error("flash_cmd_if: DATA_W must hold a command byte");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("flash_cmd_if: ADDR_W must be positive");
   end

   cmd_kind_e kind;
   rd_mode_e  mode;
   logic      job_active, suspended;
   logic      set_pgm_err, set_ers_err, set_vpp_err, clr_err;

   fci_decode u_dec (
      .cmd_byte (bus_data[CMD_W-1:0]),
      .kind     (kind)
   );

   fci_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .kind        (kind),
      .supply_ok   (supply_ok),
      .eng_done    (eng_done),
      .eng_fail    (eng_fail),
      .eng_parked  (eng_parked),
      .mode        (mode),
      .job_active  (job_active),
      .suspended   (suspended),
      .eng_start   (eng_start),
      .eng_erase   (eng_erase),
      .eng_addr    (eng_addr),
      .eng_data    (eng_data),
      .eng_hold    (eng_hold),
      .set_pgm_err (set_pgm_err),
      .set_ers_err (set_ers_err),
      .set_vpp_err (set_vpp_err),
      .clr_err     (clr_err)
   );

   fci_status #(.KEEP_SUPPLY_ERR(KEEP_SUPPLY_ERR)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .job_active  (job_active),
      .suspended   (suspended),
      .set_pgm_err (set_pgm_err),
      .set_ers_err (set_ers_err),
      .set_vpp_err (set_vpp_err),
      .clr_err     (clr_err),
      .status      (status)
   );

   assign rd_mode = mode;

   // R2: a launched job reads as busy
   a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !status[SB_READY]);
   // R9: a parked erase reads ready and suspended together
   a_r9_parked_flags: assert property (@(posedge clk) disable iff (!rst_n)
      status[SB_SUSP] |-> status[SB_READY]);

endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;

   localparam int  CLK_PERIOD = 10;
   localparam int  ADDR_W = 20;
   localparam int  DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_data = '0;
   logic              supply_ok = 1'b1;
   logic              eng_done = 1'b0;
   logic              eng_fail = 1'b0;
   logic              eng_parked = 1'b0;
   logic [1:0]        rd_mode;
   logic [7:0]        status;
   logic              eng_start, eng_erase, eng_hold;
   logic [ADDR_W-1:0] eng_addr;
   logic [DATA_W-1:0] eng_data;

   int n_chk = 0;
   int n_bad = 0;

   flash_cmd_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_data(bus_data), .supply_ok(supply_ok), .eng_done(eng_done),
      .eng_fail(eng_fail), .eng_parked(eng_parked), .rd_mode(rd_mode),
      .status(status), .eng_start(eng_start), .eng_erase(eng_erase),
      .eng_addr(eng_addr), .eng_data(eng_data), .eng_hold(eng_hold)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      bus_we = 1'b1; bus_data = d; bus_addr = a;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic done(input logic fail);
      @(negedge clk);
      eng_done = 1'b1; eng_fail = fail;
      @(negedge clk);
      eng_done = 1'b0; eng_fail = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 mode", rd_mode, 2'b00);
      chk("R1 status", status, 8'h80);
      chk("R1 start", eng_start, 0);
      chk("R1 hold", eng_hold, 0);
   endtask

   task automatic t_program();
      wr(16'h0040, 0);
      wr(16'h1234, 20'h00055);
      chk("R2 start", eng_start, 1);
      chk("R2 kind", eng_erase, 0);
      chk("R2 addr", eng_addr, 20'h00055);
      chk("R2 data", eng_data, 16'h1234);
      chk("R2 mode", rd_mode, 2'b01);
      chk("R2 busy", status, 8'h00);
      @(negedge clk);
      chk("R2 pulse", eng_start, 0);
      done(1'b0);
      chk("R5 ready", status, 8'h80);
      chk("R5 mode", rd_mode, 2'b01);
   endtask

   task automatic t_modes();
      wr(16'h00FF, 0);
      chk("R8 array", rd_mode, 2'b00);
      wr(16'h0070, 0);
      chk("R8 status", rd_mode, 2'b01);
   endtask

   task automatic t_erase_sticky();
      wr(16'h0020, 0);
      wr(16'h00D0, 20'h0003A);
      chk("R3 start", eng_start, 1);
      chk("R3 kind", eng_erase, 1);
      chk("R3 addr", eng_addr, 20'h0003A);
      chk("R3 busy", status, 8'h00);
      done(1'b1);
      chk("R5 erase fail", status, 8'hA0);
      wr(16'h0040, 0);
      wr(16'h0001, 20'h00010);
      done(1'b0);
      chk("R7 sticky", status, 8'hA0);
      wr(16'h0050, 0);
      chk("R7 clear", status, 8'h80);
      wr(16'h0040, 0);
      wr(16'h0002, 20'h00011);
      done(1'b1);
      chk("R5 program fail", status, 8'h90);
      wr(16'h0050, 0);
   endtask

   task automatic t_abort();
      wr(16'h00FF, 0);
      wr(16'h0020, 0);
      wr(16'h0040, 0);
      chk("R4 no start", eng_start, 0);
      chk("R4 status", status, 8'hB0);
      chk("R4 mode", rd_mode, 2'b01);
      wr(16'h0050, 0);
   endtask

   task automatic t_supply();
      supply_ok = 1'b0;
      wr(16'h0040, 0);
      wr(16'h0099, 20'h00001);
      chk("R6 no start pgm", eng_start, 0);
      chk("R6 pgm", status, 8'h98);
      wr(16'h0050, 0);
      wr(16'h0020, 0);
      wr(16'h00D0, 20'h00002);
      chk("R6 no start ers", eng_start, 0);
      chk("R6 ers", status, 8'hA8);
      wr(16'h0050, 0);
      supply_ok = 1'b1;
   endtask

   task automatic t_unknown();
      wr(16'h00FF, 0);
      wr(16'h0033, 0);
      chk("R12 mode kept", rd_mode, 2'b00);
      chk("R12 status kept", status, 8'h80);
      wr(16'h0020, 0);
      wr(16'h00D0, 20'h00100);
      wr(16'h00FF, 0);
      chk("R12 busy ignores FF", rd_mode, 2'b01);
      wr(16'h0040, 0);
      wr(16'h0055, 0);
      chk("R12 busy no launch", eng_start, 0);
      wr(16'h00B0, 0);
      chk("R9 hold on erase", eng_hold, 1);
      chk("R9 not yet parked", status, 8'h00);
      done(1'b0);
      chk("R12 after done", status, 8'h80);
      chk("R9 hold dropped", eng_hold, 0);
   endtask

   task automatic t_suspend();
      wr(16'h0020, 0);
      wr(16'h0011, 0);
      wr(16'h0020, 0);
      wr(16'h00D0, 20'h00200);
      chk("R3 busy with old err", status, 8'h30);
      wr(16'h00B0, 0);
      @(negedge clk);
      eng_parked = 1'b1;
      @(negedge clk);
      chk("R9 parked", status, 8'hF0);
      wr(16'h0050, 0);
      chk("R11 clear ignored", status, 8'hF0);
      chk("R11 mode kept", rd_mode, 2'b01);
      wr(16'h0040, 0);
      wr(16'h0077, 20'h00003);
      chk("R11 no launch", eng_start, 0);
      chk("R11 status after 40", status, 8'hF0);
      wr(16'h00FF, 0);
      chk("R11 susp array", rd_mode, 2'b10);
      wr(16'h00D0, 0);
      eng_parked = 1'b0;
      chk("R11 resume hold", eng_hold, 0);
      chk("R11 resume status", status, 8'h30);
      chk("R11 resume mode", rd_mode, 2'b01);
      done(1'b0);
      chk("R7 sticky after erase", status, 8'hB0);
      wr(16'h0050, 0);
   endtask

   task automatic t_suspend_other();
      wr(16'h0040, 0);
      wr(16'h0005, 20'h00004);
      wr(16'h00B0, 0);
      chk("R9 program no hold", eng_hold, 0);
      done(1'b0);
      wr(16'h0070, 0);
      wr(16'h00B0, 0);
      chk("R10 array", rd_mode, 2'b00);
      chk("R10 no hold", eng_hold, 0);
      chk("R10 status", status, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_modes();
      t_erase_sticky();
      t_abort();
      t_supply();
      t_unknown();
      t_suspend();
      t_suspend_other();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule